// File: doc/BRIEF.md
# DMA Request Generation and Priority Arbiter

This block decides when a transmit DMA engine and a receive DMA engine should ask for the system bus, and which of them gets it. Each engine has two kinds of request. A normal request waits until enough data or space exists for a long burst. An urgent request guards against a FIFO running dry on transmit or filling up on receive. The block compares the FIFO byte counts against four programmable thresholds and registers the results for one cycle. It then grants the bus to one request at a time in fixed priority order.

The grant comes out as a one-hot engine select and a flag that shows whether the winning request was urgent. A grant stays in place until the bus master reports that the transfer is done. A new grant is chosen only when no grant is held and the bus is idle. Descriptor handling, bus protocol signalling and the data movement are done elsewhere.

Top module: `dma_req_arb`

## Requirements
- R1: The transmit normal request is true when transmit FIFO free bytes are greater than or equal to the transmit burst threshold. The comparison is registered, so inputs present before clock edge k set the request at edge k.
- R2: The transmit urgent request is true when transmit FIFO occupied bytes are strictly less than the transmit urgent threshold, whatever the burst comparison gives. It is registered in the same way as R1.
- R3: The receive normal request is true only when the frame-visible input is high and receive FIFO occupied bytes are strictly greater than the receive burst threshold. It is registered in the same way as R1.
- R4: The receive urgent request is true when receive FIFO free bytes are strictly less than the receive urgent threshold. It is registered in the same way as R1.
- R5: When an engine's urgent and normal conditions are both true, only its urgent request is presented. Any resulting grant therefore has `grant_urg_o` = 1.
- R6: When no grant is held, the winner is chosen in this order, highest first: receive urgent, transmit urgent, receive normal, transmit normal.
- R7: A grant is issued only at an edge where no grant is held and `bus_idle_i` is high. It appears one edge after the request register is set.
- R8: A held grant, and its urgent flag, stay unchanged until `xfer_done_i` is sampled high. At that edge the grant clears, and it stays clear for at least one cycle. `xfer_done_i` has no effect while no grant is held.
- R9: After reset, and whenever no request is active at a granting edge, `grant_o` is 0. `grant_o` is one-hot or zero: bit 0 is the transmit engine and bit 1 is the receive engine. `grant_urg_o` is 0 whenever `grant_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_free_i | input | 12 | Transmit FIFO free bytes |
| tx_used_i | input | 12 | Transmit FIFO occupied bytes |
| rx_used_i | input | 12 | Receive FIFO occupied bytes |
| rx_free_i | input | 12 | Receive FIFO free bytes |
| rx_visible_i | input | 1 | A received frame is visible to DMA |
| tx_burst_thr_i | input | 11 | Transmit burst threshold (bytes) |
| tx_urg_thr_i | input | 11 | Transmit urgent threshold (bytes) |
| rx_burst_thr_i | input | 11 | Receive burst threshold (bytes) |
| rx_urg_thr_i | input | 11 | Receive urgent threshold (bytes) |
| bus_idle_i | input | 1 | Bus free for a new grant |
| xfer_done_i | input | 1 | Granted engine finished its transfer |
| grant_o | output | 2 | One-hot grant: bit 0 transmit, bit 1 receive |
| grant_urg_o | output | 1 | The held grant came from an urgent request |

## Verification
A change in counts or thresholds reaches the request registers at the next edge. It reaches `grant_o` one edge after that, provided no grant is held and the bus is idle. A sampled `xfer_done_i` clears the grant at that same edge. The bench drives inputs on the falling edge and advances a behavioural reference on each rising edge, in the same two-stage order: first the grant decision from the previous request state, then the request update. It compares `grant_o` and `grant_urg_o` with the reference on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_REQ  = 4;
  // priority index, lower wins
  localparam int unsigned IDX_RX_URG = 0;
  localparam int unsigned IDX_TX_URG = 1;
  localparam int unsigned IDX_RX_NRM = 2;
  localparam int unsigned IDX_TX_NRM = 3;

  typedef struct packed {
    logic urg;
    logic nrm;
  } eng_req_t;
endpackage

// File: rtl/tx_req_gen.sv
module tx_req_gen
  import dma_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned THR_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] free_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [THR_W-1:0] burst_thr_i,
  input  logic [THR_W-1:0] urg_thr_i,
  output eng_req_t         req_o
);
  logic     urg_c, nrm_c;
  eng_req_t req_q;

  always_comb begin
    urg_c = used_i < CNT_W'(urg_thr_i);
    // urgent masks normal on this engine
    nrm_c = (free_i >= CNT_W'(burst_thr_i)) && !urg_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= '{urg: urg_c, nrm: nrm_c};
  end

  assign req_o = req_q;

  p_tx_urg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_i < CNT_W'(urg_thr_i)) |=> req_q.urg);
  p_tx_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.urg |-> !req_q.nrm);
endmodule

// File: rtl/rx_req_gen.sv
module rx_req_gen
  import dma_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned THR_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] used_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic             visible_i,
  input  logic [THR_W-1:0] burst_thr_i,
  input  logic [THR_W-1:0] urg_thr_i,
  output eng_req_t         req_o
);
  logic     urg_c, nrm_c;
  eng_req_t req_q;

  always_comb begin
    urg_c = free_i < CNT_W'(urg_thr_i);
    nrm_c = visible_i && (used_i > CNT_W'(burst_thr_i)) && !urg_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= '{urg: urg_c, nrm: nrm_c};
  end

  assign req_o = req_q;

  p_rx_urg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i < CNT_W'(urg_thr_i)) |=> req_q.urg);
  p_rx_vis_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !visible_i |=> !req_q.nrm);
endmodule

// File: rtl/fixed_prio_arb.sv
module fixed_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         bus_idle_i,
  input  logic         done_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] pick_c, gnt_d, gnt_q;
  logic         held;

  // lowest index wins
  always_comb begin
    pick_c = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) pick_c = N'(1) << i;
    end
  end

  assign held = |gnt_q;

  always_comb begin
    if (held)            gnt_d = done_i ? '0 : gnt_q;
    else if (bus_idle_i) gnt_d = pick_c;
    else                 gnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  p_no_req_no_gnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q == '0 && req_i == '0) |=> gnt_q == '0);
  p_busy_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q == '0 && !bus_idle_i) |=> gnt_q == '0);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0 && !done_i) |=> gnt_q == $past(gnt_q));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0 && done_i) |=> gnt_q == '0);
  p_top_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q == '0 && bus_idle_i && req_i[0]) |=> gnt_q[0]);
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 2048,
  localparam int unsigned THR_W     = $clog2(FIFO_BYTES),
  localparam int unsigned CNT_W     = THR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tx_free_i,
  input  logic [CNT_W-1:0] tx_used_i,
  input  logic [CNT_W-1:0] rx_used_i,
  input  logic [CNT_W-1:0] rx_free_i,
  input  logic             rx_visible_i,
  input  logic [THR_W-1:0] tx_burst_thr_i,
  input  logic [THR_W-1:0] tx_urg_thr_i,
  input  logic [THR_W-1:0] rx_burst_thr_i,
  input  logic [THR_W-1:0] rx_urg_thr_i,
  input  logic             bus_idle_i,
  input  logic             xfer_done_i,
  output logic [1:0]       grant_o,
  output logic             grant_urg_o
);
  eng_req_t           tx_req, rx_req;
  logic [NUM_REQ-1:0] req_vec, gnt_vec;

  tx_req_gen #(.CNT_W(CNT_W), .THR_W(THR_W)) u_tx_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .free_i      (tx_free_i),
    .used_i      (tx_used_i),
    .burst_thr_i (tx_burst_thr_i),
    .urg_thr_i   (tx_urg_thr_i),
    .req_o       (tx_req)
  );

  rx_req_gen #(.CNT_W(CNT_W), .THR_W(THR_W)) u_rx_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .used_i      (rx_used_i),
    .free_i      (rx_free_i),
    .visible_i   (rx_visible_i),
    .burst_thr_i (rx_burst_thr_i),
    .urg_thr_i   (rx_urg_thr_i),
    .req_o       (rx_req)
  );

  always_comb begin
    req_vec             = '0;
    req_vec[IDX_RX_URG] = rx_req.urg;
    req_vec[IDX_TX_URG] = tx_req.urg;
    req_vec[IDX_RX_NRM] = rx_req.nrm;
    req_vec[IDX_TX_NRM] = tx_req.nrm;
  end

  fixed_prio_arb #(.N(NUM_REQ)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_vec),
    .bus_idle_i (bus_idle_i),
    .done_i     (xfer_done_i),
    .gnt_o      (gnt_vec)
  );

  assign grant_o[0]  = gnt_vec[IDX_TX_URG] | gnt_vec[IDX_TX_NRM];
  assign grant_o[1]  = gnt_vec[IDX_RX_URG] | gnt_vec[IDX_RX_NRM];
  assign grant_urg_o = gnt_vec[IDX_RX_URG] | gnt_vec[IDX_TX_URG];

  p_urg_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_urg_o |-> (grant_o != 2'b00));
  p_grant_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != 2'b00 && !xfer_done_i) |=> $stable(grant_urg_o));
endmodule

// File: tb/dma_req_arb_tb_top.sv
`timescale 1ns/1ps
module dma_req_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] tx_free, tx_used, rx_used, rx_free;
  logic        rx_vis, bus_idle, done;
  logic [10:0] tx_bthr, tx_uthr, rx_bthr, rx_uthr;
  logic [1:0]  grant;
  logic        grant_urg;

  always #2 clk = ~clk;

  dma_req_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_free_i(tx_free), .tx_used_i(tx_used),
    .rx_used_i(rx_used), .rx_free_i(rx_free), .rx_visible_i(rx_vis),
    .tx_burst_thr_i(tx_bthr), .tx_urg_thr_i(tx_uthr),
    .rx_burst_thr_i(rx_bthr), .rx_urg_thr_i(rx_uthr),
    .bus_idle_i(bus_idle), .xfer_done_i(done),
    .grant_o(grant), .grant_urg_o(grant_urg)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles   = 0;
  bit    finished = 0;
  string tag      = "R9";

  // reference: requests 0 rxU,1 txU,2 rxN,3 txN; granted index or -1
  bit m_req[4];
  int m_gnt = -1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_req[i] = 0;
      m_gnt = -1;
    end else begin
      bit txu, rxu;
      if (m_gnt >= 0) begin
        if (done) m_gnt = -1;
      end else if (bus_idle) begin
        for (int i = 3; i >= 0; i--) if (m_req[i]) m_gnt = i;
      end
      txu = int'(tx_used) < int'(tx_uthr);
      rxu = int'(rx_free) < int'(rx_uthr);
      m_req[0] = rxu;
      m_req[1] = txu;
      m_req[2] = rx_vis && (int'(rx_used) > int'(rx_bthr)) && !rxu;
      m_req[3] = (int'(tx_free) >= int'(tx_bthr)) && !txu;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [1:0] eg;
      logic       eu;
      eg = (m_gnt == 1 || m_gnt == 3) ? 2'b01 : (m_gnt == 0 || m_gnt == 2) ? 2'b10 : 2'b00;
      eu = (m_gnt == 0 || m_gnt == 1);
      n_checks++;
      if (grant !== eg || grant_urg !== eu) begin
        n_errors++;
        $display("FAIL %s t=%0t grant=%b urg=%b expected grant=%b urg=%b",
                 tag, $time, grant, grant_urg, eg, eu);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    tx_free = 12'd0;    tx_bthr = 11'd100;
    tx_used = 12'd2000; tx_uthr = 11'd10;
    rx_used = 12'd0;    rx_bthr = 11'd100; rx_vis = 1'b0;
    rx_free = 12'd2048; rx_uthr = 11'd10;
  endtask

  task automatic pulse_done();
    done = 1'b1; cyc(1); done = 1'b0;
  endtask

  initial begin
    quiet(); bus_idle = 1'b1; done = 1'b0;
    cyc(3);
    // R9 reset state
    n_checks++;
    if (grant !== 2'b00 || grant_urg !== 1'b0) begin
      n_errors++; $display("FAIL R9 reset grant=%b urg=%b expected 00 0", grant, grant_urg);
    end
    rst_n = 1'b1;
    tag = "R9"; cyc(5); pulse_done(); cyc(2);
    tag = "R1"; tx_free = 12'd99;  cyc(4);
    tx_free = 12'd100; cyc(4); quiet(); pulse_done(); cyc(3);
    tx_bthr = 11'd0; cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R2"; tx_used = 12'd10; cyc(4);
    tx_used = 12'd9; cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R5"; tx_used = 12'd0; tx_free = 12'd2048; cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R3"; rx_used = 12'd101; cyc(4);
    rx_vis = 1'b1; rx_used = 12'd100; cyc(4);
    rx_used = 12'd101; cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R4"; rx_free = 12'd10; cyc(4);
    rx_free = 12'd9; cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R5"; rx_free = 12'd0; rx_vis = 1'b1; rx_used = 12'd2000; cyc(4);
    quiet(); pulse_done(); cyc(3);
    tag = "R6";
    tx_free = 12'd500; tx_used = 12'd2000; rx_vis = 1'b1; rx_used = 12'd500;
    cyc(1); tx_used = 12'd5; rx_free = 12'd5; cyc(4);
    rx_free = 12'd2048; pulse_done(); cyc(3);
    tx_used = 12'd2000; pulse_done(); cyc(3);
    rx_vis = 1'b0; pulse_done(); cyc(3);
    tx_free = 12'd0; pulse_done(); cyc(3);
    tag = "R7"; bus_idle = 1'b0; tx_free = 12'd300; cyc(5);
    bus_idle = 1'b1; cyc(3);
    tag = "R8"; tx_free = 12'd0; rx_free = 12'd1; cyc(4);
    bus_idle = 1'b0; cyc(2); bus_idle = 1'b1;
    pulse_done(); cyc(4); quiet(); pulse_done(); cyc(3);
    tag = "R8"; pulse_done(); pulse_done(); cyc(3);
    tag = "R9"; cyc(5);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule